// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry Out

This block moves a data word left or right by a selectable number of bit positions, in one of six ways: logical left, logical right, arithmetic right, rotate right, rotate left, and a one-position rotate right that passes through the carry flag. The shift amount is taken either from an immediate field or from a register value. A per-operation range check rejects amounts that are not legal for the chosen operation. Rotate left is not built as its own datapath. It is converted to a rotate right by the complementary distance, so a single right-shifting barrel serves every operation.

Alongside the shifted word, the unit produces a carry bit. For ordinary shifts this is the last bit pushed out of the word. The new carry is only committed when the flag-update control is high; otherwise the incoming carry is returned as it arrived. The datapath is combinational, and both the result and the carry are captured in an output register stage, so results appear one clock after their operands.

Top module: `shrot_unit`

## Requirements
- R1: With op_i = 0 (logical left) and an amount n of 0 to 31, result_o is operand_i shifted left by n with zero fill; for n of 1 or more the computed carry is operand_i[32-n].
- R2: With op_i = 1 (logical right) and n of 1 to 32, result_o is operand_i shifted right with zero fill and the computed carry is operand_i[n-1]; n = 32 gives zero with carry equal to operand_i[31].
- R3: With op_i = 2 (arithmetic right) and n of 1 to 32, the vacated upper bits copy operand_i[31] and the computed carry is operand_i[n-1]; n = 32 gives all bits equal to the sign with carry equal to operand_i[31].
- R4: With op_i = 3 (rotate right) and n of 1 to 31, result_o is operand_i rotated right by n and the computed carry equals result_o[31].
- R5: With op_i = 5 (rotate left) and n of 1 to 31, the result and carry are identical to those of rotate right by 32-n.
- R6: With op_i = 4 (rotate right through carry) the amount is ignored; result_o is {carry_i, operand_i[31:1]} and the computed carry is operand_i[0].
- R7: Logical left by 0 returns operand_i unchanged and carry_o equal to carry_i.
- R8: An amount outside the legal range of the selected operation (logical left above 31; logical or arithmetic right of 0 or above 32; either rotate of 0 or above 31), as well as op_i codes 6 and 7, returns operand_i unchanged with carry_o equal to carry_i.
- R9: When set_flags_i is low, carry_o equals carry_i of the same operation, whatever the computed carry; when it is high, carry_o takes the computed carry.
- R10: amt_src_i = 0 selects imm_amt_i as the amount and amt_src_i = 1 selects reg_amt_i.
- R11: result_o and carry_o are registered, valid one rising clock edge after the inputs; while rst_ni is low both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (0 lsl, 1 lsr, 2 asr, 3 ror, 4 rotate through carry, 5 rol) |
| amt_src_i | input | 1 | Amount source: 0 immediate, 1 register |
| imm_amt_i | input | 6 | Immediate shift amount |
| reg_amt_i | input | 6 | Register shift amount |
| operand_i | input | 32 | Data word to shift |
| carry_i | input | 1 | Incoming carry flag |
| set_flags_i | input | 1 | Commit the computed carry |
| result_o | output | 32 | Registered shifted word |
| carry_o | output | 1 | Registered carry flag |

## Verification
The hardest situations to reach are the edges of each legal range, where a single count separates a valid full-width shift (right by 32, carry from bit 31) from a rejected amount that must leave both word and carry untouched. The stimulus sweeps every operation code, including the two unused ones, against every amount from 0 to 33 with random operands and both settings of the flag-update control. A bench-side model that moves one bit per step supplies the expected word and carry, so carry selection at each end of every range is exercised.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    SR_LSL = 3'd0,
    SR_LSR = 3'd1,
    SR_ASR = 3'd2,
    SR_ROR = 3'd3,
    SR_RRX = 3'd4,
    SR_ROL = 3'd5
  } sr_op_e;

  // internal datapath kind after legality check and rol mapping
  typedef enum logic [2:0] {
    K_PASS = 3'd0,
    K_LSL  = 3'd1,
    K_LSR  = 3'd2,
    K_ASR  = 3'd3,
    K_ROR  = 3'd4,
    K_RRX  = 3'd5
  } sr_kind_e;
endpackage

// File: rtl/shrot_amt_ctl.sv
module shrot_amt_ctl
  import shrot_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = $clog2(DW) + 1
) (
  input  logic [2:0]    op_i,
  input  logic          amt_src_i,
  input  logic [AW-1:0] imm_amt_i,
  input  logic [AW-1:0] reg_amt_i,
  output sr_kind_e      kind_o,
  output logic [AW-1:0] eff_amt_o
);
  localparam logic [AW-1:0] LIM_W  = AW'(DW);
  localparam logic [AW-1:0] LIM_W1 = AW'(DW - 1);

  logic [AW-1:0] amt;
  assign amt = amt_src_i ? reg_amt_i : imm_amt_i;

  always_comb begin
    kind_o    = K_PASS;
    eff_amt_o = amt;
    case (op_i)
      SR_LSL: if (amt <= LIM_W1) kind_o = K_LSL;
      SR_LSR: if (amt != '0 && amt <= LIM_W) kind_o = K_LSR;
      SR_ASR: if (amt != '0 && amt <= LIM_W) kind_o = K_ASR;
      SR_ROR: if (amt != '0 && amt <= LIM_W1) kind_o = K_ROR;
      SR_ROL: if (amt != '0 && amt <= LIM_W1) begin
        kind_o    = K_ROR;
        eff_amt_o = LIM_W - amt;  // left by n == right by DW-n
      end
      SR_RRX: begin
        kind_o    = K_RRX;
        eff_amt_o = AW'(1);
      end
      default: kind_o = K_PASS;
    endcase
  end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = $clog2(DW) + 1
) (
  input  logic [DW-1:0] operand_i,
  input  logic          carry_i,
  input  sr_kind_e      kind_i,
  input  logic [AW-1:0] amt_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);
  localparam int VW = 2 * DW + 1;

  logic [DW-1:0] op_rev, src, hi, shr, shr_rev;
  logic [VW-1:0] stg [AW+1];
  logic          sc;

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign op_rev[i]  = operand_i[DW-1-i];
    assign shr_rev[i] = shr[DW-1-i];
  end

  // left shifts reuse the right barrel on the bit-reversed word
  assign src = (kind_i == K_LSL) ? op_rev : operand_i;

  always_comb begin
    case (kind_i)
      K_ASR:   hi = {DW{operand_i[DW-1]}};
      K_ROR:   hi = operand_i;
      default: hi = '0;
    endcase
  end

  // guard bit at position 0 catches the last bit shifted out
  assign stg[0] = {hi, src, 1'b0};

  for (genvar s = 0; s < AW; s++) begin : g_stage
    assign stg[s+1] = amt_i[s] ? (stg[s] >> (2 ** s)) : stg[s];
  end

  assign shr = stg[AW][DW:1];
  assign sc  = stg[AW][0];

  always_comb begin
    res_o  = operand_i;
    cout_o = carry_i;
    case (kind_i)
      K_LSL: begin
        res_o  = shr_rev;
        cout_o = (amt_i == '0) ? carry_i : sc;
      end
      K_LSR, K_ASR, K_ROR: begin
        res_o  = shr;
        cout_o = sc;
      end
      K_RRX: begin
        res_o  = {carry_i, operand_i[DW-1:1]};
        cout_o = operand_i[0];
      end
      default: begin
        res_o  = operand_i;
        cout_o = carry_i;
      end
    endcase
  end
endmodule

// File: rtl/shrot_out_reg.sv
module shrot_out_reg #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] res_d_i,
  input  logic          carry_d_i,
  output logic [DW-1:0] res_q_o,
  output logic          carry_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q_o   <= '0;
      carry_q_o <= 1'b0;
    end else begin
      res_q_o   <= res_d_i;
      carry_q_o <= carry_d_i;
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = $clog2(DW) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic          amt_src_i,
  input  logic [AW-1:0] imm_amt_i,
  input  logic [AW-1:0] reg_amt_i,
  input  logic [DW-1:0] operand_i,
  input  logic          carry_i,
  input  logic          set_flags_i,
  output logic [DW-1:0] result_o,
  output logic          carry_o
);
  sr_kind_e      kind;
  logic [AW-1:0] eff_amt;
  logic [DW-1:0] res_c;
  logic          cout_c, carry_d;

  shrot_amt_ctl #(.DW(DW), .AW(AW)) u_amt (
    .op_i      (op_i),
    .amt_src_i (amt_src_i),
    .imm_amt_i (imm_amt_i),
    .reg_amt_i (reg_amt_i),
    .kind_o    (kind),
    .eff_amt_o (eff_amt)
  );

  shrot_core #(.DW(DW), .AW(AW)) u_core (
    .operand_i (operand_i),
    .carry_i   (carry_i),
    .kind_i    (kind),
    .amt_i     (eff_amt),
    .res_o     (res_c),
    .cout_o    (cout_c)
  );

  assign carry_d = set_flags_i ? cout_c : carry_i;

  shrot_out_reg #(.DW(DW)) u_oreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .res_d_i   (res_c),
    .carry_d_i (carry_d),
    .res_q_o   (result_o),
    .carry_q_o (carry_o)
  );
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int DW = 32,
  parameter int AW = $clog2(DW) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    op_i,
  input logic          amt_src_i,
  input logic [AW-1:0] imm_amt_i,
  input logic [AW-1:0] reg_amt_i,
  input logic [DW-1:0] operand_i,
  input logic          carry_i,
  input logic          set_flags_i,
  input logic [DW-1:0] result_o,
  input logic          carry_o
);
  logic          past_ok;
  logic [AW-1:0] amt_c;

  assign amt_c = amt_src_i ? reg_amt_i : imm_amt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_carry_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(set_flags_i)) |-> carry_o == $past(carry_i));

  p_rrx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(op_i) == 3'd4) |->
      result_o == {$past(carry_i), $past(operand_i[DW-1:1])});

  p_asr_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(op_i) == 3'd2 && $past(amt_c) != '0 && $past(amt_c) <= AW'(DW))
      |-> result_o[DW-1] == $past(operand_i[DW-1]));

  p_ror_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(op_i) == 3'd3 && $past(set_flags_i) &&
     $past(amt_c) != '0 && $past(amt_c) <= AW'(DW - 1))
      |-> carry_o == result_o[DW-1]);

  p_lsl_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(op_i) == 3'd0 && $past(amt_c) == '0)
      |-> (result_o == $past(operand_i) && carry_o == $past(carry_i)));

  p_bad_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(op_i) >= 3'd6)
      |-> (result_o == $past(operand_i) && carry_o == $past(carry_i)));
endmodule

bind shrot_unit shrot_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .amt_src_i   (amt_src_i),
  .imm_amt_i   (imm_amt_i),
  .reg_amt_i   (reg_amt_i),
  .operand_i   (operand_i),
  .carry_i     (carry_i),
  .set_flags_i (set_flags_i),
  .result_o    (result_o),
  .carry_o     (carry_o)
);

// File: tb/tb_shrot_unit.sv
`timescale 1ns/1ps
module tb_shrot_unit;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int NV = 12;
  localparam int WD_CYC = 100000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    op_i = '0;
  logic          amt_src_i = 1'b0;
  logic [AW-1:0] imm_amt_i = '0;
  logic [AW-1:0] reg_amt_i = '0;
  logic [DW-1:0] operand_i = '0;
  logic          carry_i = 1'b0;
  logic          set_flags_i = 1'b0;
  logic [DW-1:0] result_o;
  logic          carry_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  shrot_unit #(.DW(DW), .AW(AW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .amt_src_i(amt_src_i),
    .imm_amt_i(imm_amt_i), .reg_amt_i(reg_amt_i), .operand_i(operand_i),
    .carry_i(carry_i), .set_flags_i(set_flags_i),
    .result_o(result_o), .carry_o(carry_o)
  );

  // {op, amt, operand, cin, flags, exp_result, exp_carry}
  localparam logic [75:0] VEC [NV] = '{
    {3'd0, 6'd4,  32'hF000_000F, 1'b0, 1'b1, 32'h0000_00F0, 1'b1},  // R1
    {3'd1, 6'd32, 32'h8000_0000, 1'b0, 1'b1, 32'h0000_0000, 1'b1},  // R2
    {3'd2, 6'd32, 32'h8000_0000, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1},  // R3
    {3'd2, 6'd4,  32'h8000_0010, 1'b1, 1'b1, 32'hF800_0001, 1'b0},  // R3
    {3'd3, 6'd8,  32'h1234_5678, 1'b1, 1'b1, 32'h7812_3456, 1'b0},  // R4
    {3'd3, 6'd1,  32'h0000_0001, 1'b0, 1'b1, 32'h8000_0000, 1'b1},  // R4
    {3'd5, 6'd8,  32'h1234_5678, 1'b1, 1'b1, 32'h3456_7812, 1'b0},  // R5
    {3'd4, 6'd9,  32'h0000_0003, 1'b1, 1'b1, 32'h8000_0001, 1'b1},  // R6
    {3'd0, 6'd0,  32'hDEAD_BEEF, 1'b1, 1'b1, 32'hDEAD_BEEF, 1'b1},  // R7
    {3'd1, 6'd0,  32'h0000_0001, 1'b0, 1'b1, 32'h0000_0001, 1'b0},  // R8
    {3'd3, 6'd32, 32'h0000_00A5, 1'b1, 1'b1, 32'h0000_00A5, 1'b1},  // R8
    {3'd0, 6'd1,  32'h8000_0000, 1'b0, 1'b0, 32'h0000_0000, 1'b0}   // R9
  };

  function automatic string req_of(input logic [2:0] op, input int n);
    case (op)
      3'd0: return (n == 0) ? "R7" : ((n > 31) ? "R8" : "R1");
      3'd1: return (n == 0 || n > 32) ? "R8" : "R2";
      3'd2: return (n == 0 || n > 32) ? "R8" : "R3";
      3'd3: return (n == 0 || n > 31) ? "R8" : "R4";
      3'd4: return "R6";
      3'd5: return (n == 0 || n > 31) ? "R8" : "R5";
      default: return "R8";
    endcase
  endfunction

  // one-bit-per-step reference
  task automatic model(input logic [2:0] op, input int n, input logic [31:0] x,
                       input logic cin, input logic flg,
                       output logic [31:0] r, output logic c);
    r = x;
    c = cin;
    case (op)
      3'd0: if (n <= 31) for (int k = 0; k < n; k++) begin c = r[31]; r = r << 1; end
      3'd1: if (n >= 1 && n <= 32) for (int k = 0; k < n; k++) begin c = r[0]; r = r >> 1; end
      3'd2: if (n >= 1 && n <= 32) for (int k = 0; k < n; k++) begin c = r[0]; r = {r[31], r[31:1]}; end
      3'd3: if (n >= 1 && n <= 31) for (int k = 0; k < n; k++) begin c = r[0]; r = {r[0], r[31:1]}; end
      3'd5: if (n >= 1 && n <= 31) begin
        for (int k = 0; k < n; k++) r = {r[30:0], r[31]};
        c = r[31];
      end
      3'd4: begin r = {cin, x[31:1]}; c = x[0]; end
      default: ;
    endcase
    if (!flg) c = cin;
  endtask

  task automatic check(input string req, input logic [31:0] er, input logic ec);
    checks++;
    if (result_o !== er || carry_o !== ec) begin
      errors++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               req, result_o, carry_o, er, ec);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic src, input logic [5:0] imm,
                       input logic [5:0] rg, input logic [31:0] x,
                       input logic cin, input logic flg);
    @(negedge clk_i);
    op_i = op; amt_src_i = src; imm_amt_i = imm; reg_amt_i = rg;
    operand_i = x; carry_i = cin; set_flags_i = flg;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] er;
    logic        ec;
    logic [31:0] x;

    // R11: reset state
    repeat (3) @(negedge clk_i);
    check("R11", 32'h0, 1'b0);
    rst_ni = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][75:73], 1'b0, VEC[i][72:67], 6'd0, VEC[i][66:35],
            VEC[i][34], VEC[i][33]);
      check(req_of(VEC[i][75:73], int'(VEC[i][72:67])), VEC[i][32:1], VEC[i][0]);
    end

    // every code, every amount 0..33, random operands, both flag settings
    for (int op = 0; op < 8; op++) begin
      for (int n = 0; n <= 33; n++) begin
        for (int t = 0; t < 4; t++) begin
          x = $urandom;
          if (t == 0) x = 32'h8000_0001;
          model(3'(op), n, x, t[0], t[1] | (t == 0), er, ec);
          apply(3'(op), 1'b0, 6'(n), 6'(63 - n), x, t[0], t[1] | (t == 0));
          check(req_of(3'(op), n), er, ec);
        end
      end
    end

    // R9: flags low keeps carry_i even where computed carry differs
    apply(3'd1, 1'b0, 6'd1, 6'd0, 32'h0000_0001, 1'b0, 1'b0);
    check("R9", 32'h0, 1'b0);
    apply(3'd1, 1'b0, 6'd1, 6'd0, 32'h0000_0002, 1'b1, 1'b0);
    check("R9", 32'h1, 1'b1);

    // R10: register amount selected, immediate ignored
    apply(3'd1, 1'b1, 6'd8, 6'd4, 32'h0000_0F00, 1'b0, 1'b1);
    check("R10", 32'h0000_00F0, 1'b0);
    apply(3'd1, 1'b0, 6'd8, 6'd4, 32'h0000_0F00, 1'b0, 1'b1);
    check("R10", 32'h0000_000F, 1'b0);

    // R11: one-cycle latency, old value held before the edge
    @(negedge clk_i);
    op_i = 3'd0; amt_src_i = 1'b0; imm_amt_i = 6'd1; operand_i = 32'h1;
    carry_i = 1'b0; set_flags_i = 1'b1;
    #1 check("R11", 32'h0000_000F, 1'b0);
    @(negedge clk_i);
    check("R11", 32'h0000_0002, 1'b0);

    // R11: asynchronous reset mid-run
    rst_ni = 1'b0;
    #1 check("R11", 32'h0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule